// File: doc/BRIEF.md
# Boot Watchdog Deadman Switch

This block is a one-shot boot timer. Once the embedded processor leaves reset, the block opens a window of 2^CNT_W timebase ticks, which is 62.5 ms for an 11-bit count on a 32.768 kHz timebase. Firmware must set its disable input before the window closes. If it does not, the block stops counting and latches an overflow status flag. It then flashes an active-low LED so that a board with missing or broken boot code can be spotted by eye. The block never resets the system.

The raw timebase is a slow level input. Two flops resynchronise it into the fast system clock domain, and an edge flop turns each rising edge into a single-cycle tick. The controller has four states: Initialize, Counting, Overflow and Off. Once the block is Off, it stays Off until power-on reset, the programming-mode pin, or a change of the test input. A change of the test input also restarts a test run of the window.

Top module: `boot_deadman`

## Requirements
- R1: While `por_ni` is low, and right after it rises, `overflow_o` reads 0, `led_n_o` reads 1, and the block sits in Initialize.
- R2: Each rising edge of `tbase_i` counts as exactly one tick. A level held high counts once. A rise first sampled at clock edge n takes effect at edge n+2.
- R3: In Initialize with `test_mode_i` low, the block stays put while `cpu_rst_i` is high. It starts Counting from zero at the first edge that sees `cpu_rst_i` low.
- R4: In Counting, the 2^CNT_W-th tick (2048 by default) enters Overflow at that same edge. At that edge `overflow_o` becomes 1 and `led_n_o` becomes 0.
- R5: In Overflow, `led_n_o` inverts once every 2^LED_DIV_LOG2 ticks (8192 by default). `fw_disable_i` and `cpu_rst_i` have no effect there.
- R6: In Counting, `fw_disable_i` high moves the block to Off at the next edge. Off keeps `led_n_o` high and `overflow_o` low, whatever the ticks do and whatever later happens to `fw_disable_i`.
- R7: In Counting with `test_mode_i` low, `cpu_rst_i` high returns the block to Initialize and clears the count. A later release needs a full window again.
- R8: Any change of `test_mode_i`, rising or falling, returns the block to Initialize, clears the count and clears `overflow_o`. While `test_mode_i` stays high, Counting starts at the next edge whatever `cpu_rst_i` is.
- R9: `prog_mode_i` high forces Initialize from any state, with `led_n_o` high, for as long as it is high. It does not clear `overflow_o`.
- R10: When events coincide, the order is programming mode, then test change, then processor reset, then disable, then carry. For example, `cpu_rst_i` and `fw_disable_i` high together in Counting give Initialize, not Off.
- R11: `overflow_o` is sticky. Only power-on reset or a change of `test_mode_i` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_ni | input | 1 | Asynchronous power-on reset, active low |
| tbase_i | input | 1 | Raw slow timebase level, 32.768 kHz nominal |
| prog_mode_i | input | 1 | Programming-mode pin, high forces Initialize |
| cpu_rst_i | input | 1 | Processor held in reset when high |
| test_mode_i | input | 1 | Test control; any change restarts the window |
| fw_disable_i | input | 1 | Firmware check-in; high in Counting disables the block |
| overflow_o | output | 1 | Sticky flag: the window expired |
| led_n_o | output | 1 | Active-low indicator, flashing in Overflow |

## Verification
The assertions assume that every level of `tbase_i` lasts at least two system clocks, so that ticks stay single-cycle and isolated. They also assume that the control inputs are synchronous to `clk_i`, with only `por_ni` asynchronous. The stimulus meets this in two ways. It drives every control input a quarter period after a rising edge. It runs the timebase with a four-clock period, two clocks high and two low, and sometimes freezes it at a high level to show that a held level does not count.

// File: rtl/bdm_pkg.sv
package bdm_pkg;

   typedef enum logic [1:0] {
      BDM_INIT  = 2'd0,
      BDM_COUNT = 2'd1,
      BDM_OVF   = 2'd2,
      BDM_OFF   = 2'd3
   } bdm_state_e;

endpackage

// File: rtl/bdm_tick_sync.sv
module bdm_tick_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tbase_i,
   output logic tick_o
);

   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("bdm_tick_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   seen_q;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q[g] <= 1'b0;
            else         sync_q[g] <= tbase_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q[g] <= 1'b0;
            else         sync_q[g] <= sync_q[g-1];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seen_q <= 1'b0;
      else         seen_q <= sync_q[LAST];
   end

   assign tick_o = sync_q[LAST] & ~seen_q;

   // R2
   tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);

endmodule

// File: rtl/bdm_window_cnt.sv
module bdm_window_cnt #(
   parameter int CNT_W = 11
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic en_i,
   output logic carry_o
);

   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   if (CNT_W < 2 || CNT_W > 24) begin : g_bad_width
      $error("bdm_window_cnt: CNT_W out of range 2..24");
   end

   logic [CNT_W-1:0] cnt_q;

   assign carry_o = en_i & (cnt_q == CNT_TOP);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  cnt_q <= '0;
      else if (clr_i)               cnt_q <= '0;
      else if (en_i && !carry_o)    cnt_q <= cnt_q + 1'b1;
   end

   // R4
   cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !clr_i && !carry_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R7
   cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/bdm_led_flash.sv
module bdm_led_flash #(
   parameter int DIV_LOG2 = 13
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic active_i,
   input  logic tick_i,
   output logic led_n_o
);

   if (DIV_LOG2 < 0 || DIV_LOG2 > 24) begin : g_bad_div
      $error("bdm_led_flash: DIV_LOG2 out of range 0..24");
   end

   logic phase_q;
   logic flip;

   if (DIV_LOG2 == 0) begin : g_every_tick
      assign flip = tick_i;
   end else begin : g_divided
      localparam logic [DIV_LOG2-1:0] DIV_TOP = '1;
      logic [DIV_LOG2-1:0] div_q;

      assign flip = tick_i & (div_q == DIV_TOP);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        div_q <= '0;
         else if (!active_i) div_q <= '0;
         else if (tick_i)    div_q <= div_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        phase_q <= 1'b0;
      else if (!active_i) phase_q <= 1'b0;
      else if (flip)      phase_q <= ~phase_q;
   end

   assign led_n_o = ~active_i | phase_q;

   // R5
   led_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i && !tick_i) |=> $stable(phase_q));

endmodule

// File: rtl/boot_deadman.sv
module boot_deadman #(
   parameter int CNT_W        = 11,
   parameter int LED_DIV_LOG2 = 13,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk_i,
   input  logic por_ni,
   input  logic tbase_i,
   input  logic prog_mode_i,
   input  logic cpu_rst_i,
   input  logic test_mode_i,
   input  logic fw_disable_i,
   output logic overflow_o,
   output logic led_n_o
);
   import bdm_pkg::*;

   bdm_state_e state_q, state_d;
   logic       ovf_q, ovf_d;
   logic       test_q;
   logic       test_chg;
   logic       tick;
   logic       cnt_clr;
   logic       cnt_en;
   logic       win_carry;
   logic       hold_rst;

   assign test_chg = test_mode_i ^ test_q;
   assign hold_rst = cpu_rst_i & ~test_mode_i;

   bdm_tick_sync #(
      .SYNC_STAGES(SYNC_STAGES)
   ) i_sync (
      .clk_i  (clk_i),
      .rst_ni (por_ni),
      .tbase_i(tbase_i),
      .tick_o (tick)
   );

   assign cnt_en = (state_q == BDM_COUNT) & tick & ~prog_mode_i & ~test_chg
                   & ~hold_rst & ~fw_disable_i;

   bdm_window_cnt #(
      .CNT_W(CNT_W)
   ) i_window (
      .clk_i  (clk_i),
      .rst_ni (por_ni),
      .clr_i  (cnt_clr),
      .en_i   (cnt_en),
      .carry_o(win_carry)
   );

   bdm_led_flash #(
      .DIV_LOG2(LED_DIV_LOG2)
   ) i_led (
      .clk_i   (clk_i),
      .rst_ni  (por_ni),
      .active_i(state_q == BDM_OVF),
      .tick_i  (tick),
      .led_n_o (led_n_o)
   );

   always_comb begin
      state_d = state_q;
      ovf_d   = ovf_q;
      cnt_clr = 1'b0;
      if (prog_mode_i) begin
         state_d = BDM_INIT;
         cnt_clr = 1'b1;
      end else if (test_chg) begin
         state_d = BDM_INIT;
         cnt_clr = 1'b1;
         ovf_d   = 1'b0;
      end else begin
         unique case (state_q)
            BDM_INIT: begin
               cnt_clr = 1'b1;
               if (!hold_rst) state_d = BDM_COUNT;
            end
            BDM_COUNT: begin
               if (hold_rst) begin
                  state_d = BDM_INIT;
                  cnt_clr = 1'b1;
               end else if (fw_disable_i) begin
                  state_d = BDM_OFF;
               end else if (win_carry) begin
                  state_d = BDM_OVF;
                  ovf_d   = 1'b1;
               end
            end
            BDM_OVF: state_d = BDM_OVF;
            BDM_OFF: state_d = BDM_OFF;
            default: state_d = BDM_INIT;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) begin
         state_q <= BDM_INIT;
         ovf_q   <= 1'b0;
         test_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         ovf_q   <= ovf_d;
         test_q  <= test_mode_i;
      end
   end

   assign overflow_o = ovf_q;

   // R1
   dark_unless_ovf_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
      (state_q != BDM_OVF) |-> led_n_o);

   // R4
   carry_ovf_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
      win_carry |=> (state_q == BDM_OVF && overflow_o && !led_n_o));

   // R6
   off_hold_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
      (state_q == BDM_OFF && !prog_mode_i && !test_chg) |=> (state_q == BDM_OFF));

   // R8
   test_restart_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
      (test_chg && !prog_mode_i) |=> (state_q == BDM_INIT && !overflow_o));

   // R9
   prog_init_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
      prog_mode_i |=> (state_q == BDM_INIT && led_n_o));

   // R10
   rst_over_dis_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
      (state_q == BDM_COUNT && hold_rst && fw_disable_i && !prog_mode_i && !test_chg)
      |=> (state_q == BDM_INIT));

   // R11
   ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
      (overflow_o && !test_chg) |=> overflow_o);

endmodule

// File: tb/test_boot_deadman.sv
module test_boot_deadman;

   localparam int CW   = 11;
   localparam int LD   = 4;
   localparam int CMAX = (1 << CW) - 1;
   localparam int DIVN = 1 << LD;
   localparam int S_INIT = 0, S_CNT = 1, S_OVF = 2, S_OFF = 3;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic por_n = 1'b0, tbase = 1'b0, prog = 1'b0, cpu_rst = 1'b1, test = 1'b0, dis = 1'b0;
   logic ovf, led_n;

   boot_deadman #(.CNT_W(CW), .LED_DIV_LOG2(LD), .SYNC_STAGES(2)) i_boot_deadman (
      .clk_i(clk), .por_ni(por_n), .tbase_i(tbase), .prog_mode_i(prog),
      .cpu_rst_i(cpu_rst), .test_mode_i(test), .fw_disable_i(dis),
      .overflow_o(ovf), .led_n_o(led_n));

   int    n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit    tb_en = 1'b1;
   int    tb_div = 0;
   int    led_edges = 0;
   logic  led_prev = 1'b1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // behavioural reference
   int m_st, m_cnt, m_div;
   bit m_ovf, m_lit, m_tq, h1, h2, h3, tk, tchg;
   bit m_led_n;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_st = S_INIT; m_cnt = 0; m_div = 0; m_ovf = 0; m_lit = 0;
         m_tq = 0; h1 = 0; h2 = 0; h3 = 0;
      end else begin
         tk = h2 && !h3;
         h3 = h2; h2 = h1; h1 = tbase;
         tchg = (test != m_tq);
         m_tq = test;
         if (prog) begin
            m_st = S_INIT; m_cnt = 0;
         end else if (tchg) begin
            m_st = S_INIT; m_cnt = 0; m_ovf = 0;
         end else if (m_st == S_INIT) begin
            if (test || !cpu_rst) m_st = S_CNT;
         end else if (m_st == S_CNT) begin
            if (cpu_rst && !test) begin
               m_st = S_INIT; m_cnt = 0;
            end else if (dis) begin
               m_st = S_OFF;
            end else if (tk) begin
               if (m_cnt == CMAX) begin
                  m_st = S_OVF; m_ovf = 1; m_lit = 1; m_div = 0;
               end else m_cnt++;
            end
         end else if (m_st == S_OVF) begin
            if (tk) begin
               if (m_div == DIVN - 1) begin
                  m_div = 0; m_lit = !m_lit;
               end else m_div++;
            end
         end
      end
      m_led_n = !(m_st == S_OVF && m_lit);
   end

   initial m_led_n = 1'b1;

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      check(led_n == m_led_n, cur_req, int'(led_n), int'(m_led_n));
      check(ovf == m_ovf, cur_req, int'(ovf), int'(m_ovf));
      if (led_n !== led_prev) led_edges++;
      led_prev = led_n;
   end

   // timebase: four-clock period
   initial begin
      forever begin
         @(posedge clk); #5;
         if (tb_en) begin
            tb_div++;
            if (tb_div == 2) begin
               tbase = ~tbase;
               tb_div = 0;
            end
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int e0, waited;
      step(4);
      check(led_n == 1'b1, "R1", int'(led_n), 1);
      check(ovf == 1'b0, "R1", int'(ovf), 0);
      por_n = 1'b1;
      step(2);
      check(led_n == 1'b1 && ovf == 1'b0, "R1", int'(ovf), 0);

      cur_req = "R3";
      step(9000);
      check(ovf == 1'b0, "R3", int'(ovf), 0);

      cur_req = "R4";
      cpu_rst = 1'b0;
      waited = 0;
      while (!ovf && waited < 9000) begin step(1); waited++; end
      check(waited >= 8188 && waited <= 8200, "R4", waited, 8192);
      check(led_n == 1'b0, "R4", int'(led_n), 0);

      cur_req = "R5";
      dis = 1'b1; cpu_rst = 1'b1;
      e0 = led_edges;
      step(640);
      check(led_edges - e0 == 10, "R5", led_edges - e0, 10);
      check(ovf == 1'b1, "R5", int'(ovf), 1);
      dis = 1'b0;

      cur_req = "R8";
      test = 1'b1;
      step(2);
      check(ovf == 1'b0, "R8", int'(ovf), 0);
      check(led_n == 1'b1, "R8", int'(led_n), 1);
      step(8300);
      check(ovf == 1'b1, "R8", int'(ovf), 1);

      cur_req = "R11";
      test = 1'b0;
      step(2);
      check(ovf == 1'b0, "R11", int'(ovf), 0);

      cur_req = "R6";
      cpu_rst = 1'b0;
      step(1000);
      dis = 1'b1;
      step(3);
      dis = 1'b0;
      step(9000);
      check(ovf == 1'b0, "R6", int'(ovf), 0);
      check(led_n == 1'b1, "R6", int'(led_n), 1);

      cur_req = "R9";
      prog = 1'b1;
      step(20);
      check(led_n == 1'b1, "R9", int'(led_n), 1);
      prog = 1'b0;
      step(8300);
      check(ovf == 1'b1, "R9", int'(ovf), 1);
      prog = 1'b1;
      step(5);
      check(ovf == 1'b1, "R9", int'(ovf), 1);
      check(led_n == 1'b1, "R9", int'(led_n), 1);

      cur_req = "R10";
      test = 1'b1;
      step(3);
      check(ovf == 1'b1, "R10", int'(ovf), 1);
      cpu_rst = 1'b1;
      prog = 1'b0;
      step(3);
      test = 1'b0;
      step(2);
      check(ovf == 1'b0, "R11", int'(ovf), 0);

      cur_req = "R7";
      cpu_rst = 1'b0;
      step(4000);
      cpu_rst = 1'b1;
      step(10);
      cpu_rst = 1'b0;
      step(5000);
      check(ovf == 1'b0, "R7", int'(ovf), 0);
      step(3400);
      check(ovf == 1'b1, "R7", int'(ovf), 1);

      cur_req = "R11";
      por_n = 1'b0;
      step(2);
      check(ovf == 1'b0, "R11", int'(ovf), 0);
      por_n = 1'b1;

      cur_req = "R10";
      step(100);
      dis = 1'b1; cpu_rst = 1'b1;
      step(1);
      dis = 1'b0; cpu_rst = 1'b0;
      step(8400);
      check(ovf == 1'b1, "R10", int'(ovf), 1);

      cur_req = "R2";
      cpu_rst = 1'b1; test = 1'b1;
      step(2);
      test = 1'b0;
      step(2);
      cpu_rst = 1'b0;
      while (!tbase) step(1);
      tb_en = 1'b0;
      step(9000);
      check(ovf == 1'b0, "R2", int'(ovf), 0);
      tb_en = 1'b1;
      step(8400);
      check(ovf == 1'b1, "R2", int'(ovf), 1);

      finish_run();
   end

endmodule